// File: doc/BRIEF.md
# Masked BSSID receive address filter

This block decides, for every received frame, whether the frame's 48-bit BSSID belongs to the station so that the receiver may acknowledge it. It holds a programmable 48-bit station address and a 48-bit BSSID mask. Only the bit positions that are set in the mask take part in the compare. A single station address can therefore cover several virtual BSSes that differ only in masked-out bits. The price is that some frames that are not addressed to the station also pass.

Software programs the address and the mask through a small 32-bit register port: four word registers, split into low and high halves. The frame path presents a BSSID together with a valid strobe. One clock later the block returns an accept flag together with its own valid strobe. A new compare may start on every cycle.

Top module: `bssid_rx_filter`

## Requirements
- R1: A result reports accept=1 exactly when (frame BSSID AND mask) equals (station address AND mask), with both sides taken from the configuration as it stood in the strobe cycle.
- R2: Address byte k occupies bits [8k+7:8k] of every 48-bit value. Register 0 holds station address bytes 0..3, with byte 0 in bits [7:0]. Bits [15:0] of register 1 hold bytes 4 and 5. Registers 2 and 3 hold the mask in the same way.
- R3: Bits [31:16] of register 1 form a control field. It is stored on a write to register 1 and read back unchanged. It has no effect on any compare, so a read-modify-write of register 1 that changes the address keeps it.
- R4: A read of any register returns the stored value. Bits [31:16] of register 3 always read as zero.
- R5: After reset the station address and the control field are zero, the mask is all ones (register 3 reads 0x0000FFFF), and no result valid is raised.
- R6: With an all-ones mask, a frame is accepted only when all 48 bits equal the station address.
- R7: With an all-zeros mask, every frame is accepted.
- R8: The result valid rises exactly one clock after each BSSID strobe, back-to-back strobes give back-to-back results, and there is no result without a strobe.
- R9: With station address 0x000000000001 and mask 0x000000000002, the BSSIDs 0x1, 0x4, 0x9 and 0xD are accepted and 0x6 is rejected.
- R10: A register write in the same cycle as a strobe does not affect that frame's result; it applies from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select (0: address low, 1: address high and control, 2: mask low, 3: mask high) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| bssid_valid | input | 1 | BSSID strobe |
| bssid | input | 48 | Received frame BSSID, byte k in bits [8k+7:8k] |
| acc_valid | output | 1 | Result strobe, one clock after bssid_valid |
| acc_match | output | 1 | 1 when the frame is accepted, valid with acc_valid |

## Verification
The assertions assume that reset is held for at least one clock edge before the first strobe or write. They also assume that the inputs are stable around the rising edge, and that cfg_addr always carries one of the four defined selects. The stimulus changes every input only on the falling clock edge. It holds reset low over several edges, and drives writes and strobes only after reset has been released. It still freely mixes writes to every register with single and back-to-back strobes, including writes that land in the same cycle as a strobe.

// File: rtl/bssid_filt_pkg.sv
package bssid_filt_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int ADDR_W  = WORD_W + HALF_W;
    localparam int BYTES_N = ADDR_W / 8;

    typedef enum logic [1:0] {
        SEL_ADR_LO = 2'd0,
        SEL_ADR_HI = 2'd1,
        SEL_MSK_LO = 2'd2,
        SEL_MSK_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] adr_lo;
        logic [HALF_W-1:0] adr_hi;
        logic [HALF_W-1:0] ctl;
        logic [WORD_W-1:0] msk_lo;
        logic [HALF_W-1:0] msk_hi;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic match;
    } res_t;
endpackage

// File: rtl/bssid_filt_regs.sv
module bssid_filt_regs
    import bssid_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] sta_adr,
    output logic [ADDR_W-1:0] sta_msk
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (reg_sel_e'(addr))
                SEL_ADR_LO: cfg_d.adr_lo = wdata;
                SEL_ADR_HI: begin
                    cfg_d.adr_hi = wdata[HALF_W-1:0];
                    cfg_d.ctl    = wdata[WORD_W-1:HALF_W];
                end
                SEL_MSK_LO: cfg_d.msk_lo = wdata;
                SEL_MSK_HI: cfg_d.msk_hi = wdata[HALF_W-1:0];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.adr_lo <= '0;
            cfg_q.adr_hi <= '0;
            cfg_q.ctl    <= '0;
            cfg_q.msk_lo <= '1;
            cfg_q.msk_hi <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_ADR_LO: rdata = cfg_q.adr_lo;
            SEL_ADR_HI: rdata = {cfg_q.ctl, cfg_q.adr_hi};
            SEL_MSK_LO: rdata = cfg_q.msk_lo;
            SEL_MSK_HI: rdata = {{(WORD_W-HALF_W){1'b0}}, cfg_q.msk_hi};
            default:    rdata = '0;
        endcase
    end

    assign sta_adr = {cfg_q.adr_hi, cfg_q.adr_lo};
    assign sta_msk = {cfg_q.msk_hi, cfg_q.msk_lo};

    // R2: a low-word write lands in address bytes 0..3
    a_r2_adr_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0) |=> (sta_adr[WORD_W-1:0] == $past(wdata)));

    // R3: control field only changes on a write to register 1
    a_r3_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == 2'd1) |=> $stable(cfg_q.ctl));

    // R4: upper half of register 3 reads as zero
    a_r4_msk_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata[WORD_W-1:HALF_W] == '0));
endmodule

// File: rtl/bssid_filt_cmp.sv
module bssid_filt_cmp
    import bssid_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_bssid,
    input  logic [ADDR_W-1:0] sta_adr,
    input  logic [ADDR_W-1:0] sta_msk,
    output logic              out_valid,
    output logic              out_match
);
    logic [BYTES_N-1:0] byte_ok;
    res_t res_d, res_q;

    for (genvar b = 0; b < BYTES_N; b++) begin : g_byte
        logic [7:0] diff;
        assign diff       = (in_bssid[8*b +: 8] ^ sta_adr[8*b +: 8]) & sta_msk[8*b +: 8];
        assign byte_ok[b] = (diff == 8'h00);
    end

    always_comb begin
        res_d.valid = in_valid;
        res_d.match = in_valid & (&byte_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_match = res_q.match;

    // R8: one result per strobe, one clock later
    a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: empty mask accepts everything
    a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sta_msk == '0) |=> out_match);

    // R6: full mask is an exact compare
    a_r6_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sta_msk == '1) |=> (out_match == ($past(in_bssid) == $past(sta_adr))));
endmodule

// File: rtl/bssid_rx_filter.sv
module bssid_rx_filter
    import bssid_filt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        bssid_valid,
    input  logic [47:0] bssid,
    output logic        acc_valid,
    output logic        acc_match
);
    logic [ADDR_W-1:0] sta_adr;
    logic [ADDR_W-1:0] sta_msk;

    bssid_filt_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .sta_adr (sta_adr),
        .sta_msk (sta_msk)
    );

    bssid_filt_cmp i_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (bssid_valid),
        .in_bssid  (bssid),
        .sta_adr   (sta_adr),
        .sta_msk   (sta_msk),
        .out_valid (acc_valid),
        .out_match (acc_match)
    );

    // R5: no result in the first cycle after reset
    a_r5_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !acc_valid);
endmodule

// File: tb/test_bssid_rx_filter.sv
module test_bssid_rx_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bssid_valid = 1'b0;
    logic [47:0] bssid = '0;
    logic        acc_valid, acc_match;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R5";

    bssid_rx_filter i_bssid_rx_filter (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .bssid_valid, .bssid, .acc_valid, .acc_match
    );

    always #2ns clk = ~clk;

    // behavioural reference model
    logic [47:0] m_adr, m_msk;
    logic [15:0] m_ctl;
    bit          e_valid, e_match;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_adr   <= '0;
            m_ctl   <= '0;
            m_msk   <= {48{1'b1}};
            e_valid <= 1'b0;
            e_match <= 1'b0;
        end else begin
            e_valid <= bssid_valid;
            e_match <= bssid_valid && ((bssid & m_msk) == (m_adr & m_msk));
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_adr[31:0] <= cfg_wdata;
                    2'd1: begin m_adr[47:32] <= cfg_wdata[15:0]; m_ctl <= cfg_wdata[31:16]; end
                    2'd2: m_msk[31:0] <= cfg_wdata;
                    default: m_msk[47:32] <= cfg_wdata[15:0];
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_adr[31:0];
            2'd1:    return {m_ctl, m_adr[47:32]};
            2'd2:    return m_msk[31:0];
            default: return {16'h0, m_msk[47:32]};
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, "/R8 valid"}, 64'(acc_valid), 64'(e_valid));
            if (e_valid) check({cur_req, "/R1 match"}, 64'(acc_match), 64'(e_match));
            check({cur_req, "/R4 rdata"}, 64'(cfg_rdata), 64'(exp_rd(cfg_addr)));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [47:0] b);
        bssid_valid = 1'b1; bssid = b;
        @(negedge clk);
        bssid_valid = 1'b0;
    endtask

    task automatic expect_one(input string req, input logic [47:0] b, input bit acc);
        bssid_valid = 1'b1; bssid = b;
        @(negedge clk);
        bssid_valid = 1'b0;
        check(req, {62'h0, acc_valid, acc_match}, {62'h0, 1'b1, acc});
    endtask

    task automatic read_all();
        for (int a = 0; a < 4; a++) begin
            cfg_addr = 2'(a);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state
        cur_req = "R5";
        check("R5 idle", 64'(acc_valid), 64'd0);
        cfg_addr = 2'd3; #0.1ns;
        check("R5 mask hi", 64'(cfg_rdata), 64'h0000ffff);
        cfg_addr = 2'd1; #0.1ns;
        check("R5 adr hi", 64'(cfg_rdata), 64'h0);
        @(negedge clk);
        read_all();

        // R6: exact match with reset mask
        cur_req = "R6";
        wr(2'd0, 32'h33221100);
        wr(2'd1, 32'h00005544);
        expect_one("R6 equal", 48'h554433221100, 1'b1);
        expect_one("R6 one bit off", 48'h554433221101, 1'b0);
        expect_one("R6 top bit off", 48'hd54433221100, 1'b0);

        // R2: byte placement in registers
        cur_req = "R2";
        cfg_addr = 2'd0; #0.1ns;
        check("R2 adr lo", 64'(cfg_rdata), 64'h33221100);
        cfg_addr = 2'd1; #0.1ns;
        check("R2 adr hi", 64'(cfg_rdata), 64'h00005544);
        @(negedge clk);

        // R3: control field kept across read-modify-write
        cur_req = "R3";
        wr(2'd1, 32'hbeef5544);
        cfg_addr = 2'd1; #0.1ns;
        wr(2'd1, {cfg_rdata[31:16], 16'h7766});
        cfg_addr = 2'd1; #0.1ns;
        check("R3 ctl kept", 64'(cfg_rdata), 64'hbeef7766);
        expect_one("R3 ctl no effect", 48'h776633221100, 1'b1);

        // R4: upper bits of register 3 read zero
        cur_req = "R4";
        wr(2'd3, 32'hffff1234);
        cfg_addr = 2'd3; #0.1ns;
        check("R4 msk hi", 64'(cfg_rdata), 64'h00001234);
        read_all();

        // R9: scaled 4-bit illustration
        cur_req = "R9";
        wr(2'd0, 32'h1); wr(2'd1, 32'hbeef0000);
        wr(2'd2, 32'h2); wr(2'd3, 32'h0);
        expect_one("R9 0x1", 48'h1, 1'b1);
        expect_one("R9 0x4", 48'h4, 1'b1);
        expect_one("R9 0x9", 48'h9, 1'b1);
        expect_one("R9 0xD", 48'hd, 1'b1);
        expect_one("R9 0x6", 48'h6, 1'b0);

        // R7: empty mask accepts all
        cur_req = "R7";
        wr(2'd2, 32'h0);
        expect_one("R7 any", 48'hfedcba987654, 1'b1);
        expect_one("R7 ones", {48{1'b1}}, 1'b1);

        // R10: write in the strobe cycle applies afterwards
        cur_req = "R10";
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'hffffffff;
        bssid_valid = 1'b1; bssid = 48'h0000_0000_0f00;
        @(negedge clk);
        cfg_we = 1'b0; bssid_valid = 1'b0;
        check("R10 old mask", {62'h0, acc_valid, acc_match}, 64'h3);
        expect_one("R10 new mask", 48'h0000_0000_0f00, 1'b0);

        // R8 and R1: back-to-back strobes with random data and masks
        cur_req = "R1";
        for (int i = 0; i < 400; i++) begin
            cfg_we    = ($urandom_range(0, 3) == 0);
            cfg_addr  = 2'($urandom_range(0, 3));
            cfg_wdata = (i % 3 == 0) ? 32'hffff_ffff : $urandom();
            bssid_valid = ($urandom_range(0, 3) != 0);
            bssid = ($urandom_range(0, 1) == 1) ? {m_adr[47:8], 8'($urandom())}
                                               : {16'($urandom()), 32'($urandom())};
            @(negedge clk);
        end
        cfg_we = 1'b0; bssid_valid = 1'b0;
        cur_req = "R8";
        for (int i = 0; i < 5; i++) send(48'(i));
        @(negedge clk);
        check("R8 idle", 64'(acc_valid), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule